// File: doc/BRIEF.md
# Shared Open-Drain Sequencing Tick Agent

Several power-management devices on a board agree on one time base through a single wired-AND line. Each device either pulls the line low or lets it float, and a board pull-up takes it high only when every device has let go. This block is the per-device agent for that line. It makes its own share of the low and high halves of a nominally 100 kHz clock from a divided local clock. It also follows the line: any other device that holds the line low lengthens the period, and any device that pulls early starts the next low half at once.

While the local side reports not ready, or reports a fault, the agent holds the line low. This stops the shared clock for everyone and clears the local tick count. Once the agent lets go, the first rising edge it sees on the line is time zero. Every later rising edge adds one tick. Two programmable tick values fire a rail-enable event and a rail-disable event, and these drive a rail-enable level. A watchdog raises a stall flag when the running clock stops for too long.

The block carries no data stream, so it has no valid/ready interface. All of its pins are plain control and status levels or single-cycle pulses.

Top module: `share_tick_agent`

## Requirements
- R1: After reset the agent pulls the line low (line_pull_o=1), and tick_o=0, rail_en_o=0, time_zero_o=0, on_evt_o=0, off_evt_o=0, stall_o=0.
- R2: While ready_i=0 or fault_i=1, line_pull_o is 1 from the next clock edge on, tick_o is 0 and rail_en_o is 0.
- R3: When free running with no other device pulling, each low half lasts exactly HALF_DIV clock cycles of line_pull_o=1.
- R4: After its own low half, the agent releases the line (line_pull_o=0). It starts counting its high half only after it has seen the synchronized line high, so a device that holds the line low stretches the period.
- R5: line_i passes through SYNC_STAGES (default 2) flip-flops and then an edge register. A rising edge of line_i first changes tick and watchdog state on the third clock edge after the rise.
- R6: The first rising edge seen after the agent stops holding is time zero: time_zero_o pulses for one cycle and tick_o is 0.
- R7: Each later rising edge adds 1 to tick_o. The count saturates at 2^CNT_W-1.
- R8: When a tick update gives tick_o equal to on_at_i, on_evt_o pulses with that update and rail_en_o goes to 1.
- R9: When a tick update gives tick_o equal to off_at_i, off_evt_o pulses and rail_en_o goes to 0. If on_at_i equals off_at_i, the disable event wins.
- R10: If the line goes low during the agent's high half, the agent begins its low half as soon as the synchronized line shows it, without waiting for its own high count to end.
- R11: After time zero, stall_o goes to 1 once WDOG_MULT*2*HALF_DIV cycles pass with no rising edge. A rising edge clears stall_o on the same edge that updates the tick.
- R12: Dropping ready_i in the middle of a run clears tick_o and rail_en_o and pulls the line low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_i | input | 1 | Local side is ready; 0 holds the shared line low |
| fault_i | input | 1 | Local fault; 1 holds the shared line low |
| on_at_i | input | CNT_W | Tick value of the rail-enable event |
| off_at_i | input | CNT_W | Tick value of the rail-disable event |
| line_i | input | 1 | Sampled level of the shared line (asynchronous) |
| line_pull_o | output | 1 | 1 pulls the shared line low, 0 releases it |
| tick_o | output | CNT_W | Ticks since time zero |
| time_zero_o | output | 1 | One-cycle pulse at time zero |
| on_evt_o | output | 1 | One-cycle rail-enable event |
| off_evt_o | output | 1 | One-cycle rail-disable event |
| rail_en_o | output | 1 | Rail-enable level |
| stall_o | output | 1 | Shared clock stopped too long |

## Verification
The outputs fall due at different times. A change on ready_i or fault_i shows on line_pull_o after one edge. A low driven by another device reaches the agent's phase logic two edges after the line falls. A line rise reaches tick_o, the event pulses and stall_o on the third edge. The bench models the wired-AND line with a second device, and it keeps a behavioural model that steps at every rising edge from the same inputs. It compares every output at the falling edge, after all registered updates have settled. The directed checks count falling edges from a known line transition so that they sample in exactly the cycle each result is due.

// File: rtl/share_tick_pkg.sv
package share_tick_pkg;
  // Line-drive phase of the agent
  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,  // held low: not ready or fault
    PH_LOW  = 2'd1,  // own low half
    PH_WAIT = 2'd2,  // released, waiting to see the line high
    PH_HIGH = 2'd3   // own high half
  } phase_t;
endpackage

// File: rtl/sta_sync.sv
module sta_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic level_o,
  output logic rise_o
);
  // STAGES synchronizer flops plus one edge register
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], d_i};
  end

  assign level_o = sh[STAGES-1];
  assign rise_o  = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/sta_phase_gen.sv
module sta_phase_gen
  import share_tick_pkg::*;
#(
  parameter int HALF_DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic line_lvl_i,
  output logic pull_o
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  phase_t        ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_HOLD;
      cnt <= '0;
    end else if (hold_i) begin
      ph  <= PH_HOLD;
      cnt <= '0;
    end else begin
      unique case (ph)
        PH_HOLD: begin
          ph  <= PH_WAIT;
          cnt <= '0;
        end
        PH_LOW: begin
          if (cnt == LAST) begin
            ph  <= PH_WAIT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_WAIT: begin
          // stretch: another device may still hold the line low
          if (line_lvl_i) begin
            ph  <= PH_HIGH;
            cnt <= '0;
          end
        end
        PH_HIGH: begin
          // track: an early low from another device starts our low half
          if (!line_lvl_i || cnt == LAST) begin
            ph  <= PH_LOW;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          ph  <= PH_HOLD;
          cnt <= '0;
        end
      endcase
    end
  end

  assign pull_o = (ph == PH_HOLD) || (ph == PH_LOW);
endmodule

// File: rtl/sta_tick_events.sv
module sta_tick_events #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] on_at_i,
  input  logic [CNT_W-1:0] off_at_i,
  output logic [CNT_W-1:0] tick_o,
  output logic             started_o,
  output logic             tz_o,
  output logic             on_evt_o,
  output logic             off_evt_o,
  output logic             rail_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] nxt;

  always_comb begin
    if (!started_o)        nxt = '0;
    else if (tick_o == TOP) nxt = tick_o;
    else                   nxt = tick_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_o    <= '0;
      started_o <= 1'b0;
      tz_o      <= 1'b0;
      on_evt_o  <= 1'b0;
      off_evt_o <= 1'b0;
      rail_o    <= 1'b0;
    end else if (hold_i) begin
      tick_o    <= '0;
      started_o <= 1'b0;
      tz_o      <= 1'b0;
      on_evt_o  <= 1'b0;
      off_evt_o <= 1'b0;
      rail_o    <= 1'b0;
    end else if (rise_i) begin
      tick_o    <= nxt;
      started_o <= 1'b1;
      tz_o      <= ~started_o;
      on_evt_o  <= (nxt == on_at_i);
      off_evt_o <= (nxt == off_at_i);
      if (nxt == off_at_i)     rail_o <= 1'b0;
      else if (nxt == on_at_i) rail_o <= 1'b1;
    end else begin
      tz_o      <= 1'b0;
      on_evt_o  <= 1'b0;
      off_evt_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sta_stall_wd.sv
module sta_stall_wd #(
  parameter int LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic started_i,
  input  logic rise_i,
  output logic stall_o
);
  localparam int WW = $clog2(LIMIT + 1);
  localparam logic [WW-1:0] LAST = WW'(LIMIT - 1);

  logic [WW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      stall_o <= 1'b0;
    end else if (hold_i || !started_i || rise_i) begin
      cnt     <= '0;
      stall_o <= 1'b0;
    end else if (cnt == LAST) begin
      stall_o <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/share_tick_agent.sv
module share_tick_agent #(
  parameter int HALF_DIV    = 250,
  parameter int CNT_W       = 16,
  parameter int WDOG_MULT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready_i,
  input  logic             fault_i,
  input  logic [CNT_W-1:0] on_at_i,
  input  logic [CNT_W-1:0] off_at_i,
  input  logic             line_i,
  output logic             line_pull_o,
  output logic [CNT_W-1:0] tick_o,
  output logic             time_zero_o,
  output logic             on_evt_o,
  output logic             off_evt_o,
  output logic             rail_en_o,
  output logic             stall_o
);
  localparam int WD_LIMIT = WDOG_MULT * 2 * HALF_DIV;

  logic hold;
  logic line_lvl;
  logic line_rise;
  logic started;

  assign hold = ~ready_i | fault_i;

  sta_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_i     (line_i),
    .level_o (line_lvl),
    .rise_o  (line_rise)
  );

  sta_phase_gen #(.HALF_DIV(HALF_DIV)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_i     (hold),
    .line_lvl_i (line_lvl),
    .pull_o     (line_pull_o)
  );

  sta_tick_events #(.CNT_W(CNT_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (hold),
    .rise_i    (line_rise),
    .on_at_i   (on_at_i),
    .off_at_i  (off_at_i),
    .tick_o    (tick_o),
    .started_o (started),
    .tz_o      (time_zero_o),
    .on_evt_o  (on_evt_o),
    .off_evt_o (off_evt_o),
    .rail_o    (rail_en_o)
  );

  sta_stall_wd #(.LIMIT(WD_LIMIT)) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (hold),
    .started_i (started),
    .rise_i    (line_rise),
    .stall_o   (stall_o)
  );
endmodule

// File: rtl/share_tick_agent_chk.sv
module share_tick_agent_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready_i,
  input logic             fault_i,
  input logic             line_pull_o,
  input logic [CNT_W-1:0] tick_o,
  input logic             time_zero_o,
  input logic             on_evt_o,
  input logic             off_evt_o,
  input logic             rail_en_o,
  input logic             stall_o
);
  logic hold;
  assign hold = !ready_i || fault_i;

  // R2
  hold_pulls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (line_pull_o && tick_o == '0 && !rail_en_o));

  // R6
  tz_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_zero_o |-> (tick_o == '0 && !stall_o));

  // R7
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(hold) && tick_o != $past(tick_o)) |-> (tick_o == CNT_W'($past(tick_o) + 1'b1)));

  // R8
  on_sets_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_evt_o && !off_evt_o) |-> rail_en_o);

  // R9
  off_clears_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_evt_o |-> !rail_en_o);

  // R11
  stall_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> !$past(hold));
endmodule

bind share_tick_agent share_tick_agent_chk #(.CNT_W(CNT_W)) u_share_tick_agent_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ready_i     (ready_i),
  .fault_i     (fault_i),
  .line_pull_o (line_pull_o),
  .tick_o      (tick_o),
  .time_zero_o (time_zero_o),
  .on_evt_o    (on_evt_o),
  .off_evt_o   (off_evt_o),
  .rail_en_o   (rail_en_o),
  .stall_o     (stall_o)
);

// File: tb/share_tick_agent_bench.sv
module share_tick_agent_bench;
  localparam int HD   = 4;
  localparam int CW   = 4;
  localparam int WM   = 3;
  localparam int LIM  = WM * 2 * HD;
  localparam int TMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ready = 1'b0;
  logic fault = 1'b0;
  logic other = 1'b0;
  logic [CW-1:0] on_at = '0;
  logic [CW-1:0] off_at = '0;
  logic line;
  logic pull, tz, on_evt, off_evt, rail, stall;
  logic [CW-1:0] tick;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // wired-AND shared line with a second device
  assign line = !(pull || other);

  share_tick_agent #(.HALF_DIV(HD), .CNT_W(CW), .WDOG_MULT(WM)) u_share_tick_agent (
    .clk(clk), .rst_n(rst_n), .ready_i(ready), .fault_i(fault),
    .on_at_i(on_at), .off_at_i(off_at), .line_i(line),
    .line_pull_o(pull), .tick_o(tick), .time_zero_o(tz),
    .on_evt_o(on_evt), .off_evt_o(off_evt), .rail_en_o(rail), .stall_o(stall)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_ph = 0;   // 0 held, 1 low, 2 waiting, 3 high
  int m_cnt = 0;
  int m_sync[$] = '{0, 0, 0};  // oldest last
  int m_started = 0, m_tick = 0, m_tz = 0, m_on = 0, m_off = 0, m_rail = 0;
  int m_wd = 0, m_stall = 0;

  always @(posedge clk) begin
    int hold_now, m_line, rise, nt, m_pull;
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_sync = '{0, 0, 0};
      m_started = 0; m_tick = 0; m_tz = 0; m_on = 0; m_off = 0; m_rail = 0;
      m_wd = 0; m_stall = 0;
    end else begin
      hold_now = (!ready || fault) ? 1 : 0;
      m_pull = (m_ph <= 1) ? 1 : 0;
      m_line = (m_pull == 1 || other) ? 0 : 1;
      rise = (m_sync[1] == 1 && m_sync[2] == 0) ? 1 : 0;
      // watchdog, using the run state before this edge
      if (hold_now == 1 || m_started == 0 || rise == 1) begin m_wd = 0; m_stall = 0; end
      else if (m_wd == LIM - 1) m_stall = 1;
      else m_wd++;
      // ticks and events
      if (hold_now == 1) begin
        m_started = 0; m_tick = 0; m_tz = 0; m_on = 0; m_off = 0; m_rail = 0;
      end else if (rise == 1) begin
        nt = (m_started == 0) ? 0 : ((m_tick == TMAX) ? TMAX : m_tick + 1);
        m_tz = (m_started == 0) ? 1 : 0;
        m_started = 1;
        m_tick = nt;
        m_on = (nt == int'(on_at)) ? 1 : 0;
        m_off = (nt == int'(off_at)) ? 1 : 0;
        if (m_off == 1) m_rail = 0;
        else if (m_on == 1) m_rail = 1;
      end else begin
        m_tz = 0; m_on = 0; m_off = 0;
      end
      // line phase
      if (hold_now == 1) begin m_ph = 0; m_cnt = 0; end
      else if (m_ph == 0) begin m_ph = 2; m_cnt = 0; end
      else if (m_ph == 1) begin
        if (m_cnt == HD - 1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
      end else if (m_ph == 2) begin
        if (m_sync[1] == 1) begin m_ph = 3; m_cnt = 0; end
      end else begin
        if (m_sync[1] == 0 || m_cnt == HD - 1) begin m_ph = 1; m_cnt = 0; end else m_cnt++;
      end
      void'(m_sync.pop_back());
      m_sync.push_front(m_line);
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R3 R4 R10 model line_pull", pull, (m_ph <= 1) ? 1 : 0);
      chk("R7 model tick", tick, m_tick);
      chk("R6 model time_zero", tz, m_tz);
      chk("R8 model on_evt", on_evt, m_on);
      chk("R9 model off_evt", off_evt, m_off);
      chk("R8 R9 model rail_en", rail, m_rail);
      chk("R11 model stall", stall, m_stall);
    end
  end

  // watchdog for a hung run
  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wait_for(input string what, ref logic sig);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (sig === 1'b1) return;
    end
    chk({"timeout waiting for ", what}, 0, 1);
  endtask

  initial begin
    int lowlen;
    logic prev;
    bit saw_rail;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 reset line_pull", pull, 1);
    chk("R1 reset tick", tick, 0);
    chk("R1 reset rail_en", rail, 0);
    chk("R1 reset time_zero", tz, 0);
    chk("R1 reset stall", stall, 0);
    chk("R1 reset events", {on_evt, off_evt}, 0);
    cmp_en = 1'b1;

    // R2 not ready holds the line
    repeat (20) @(negedge clk);
    chk("R2 not ready pull", pull, 1);
    chk("R2 not ready tick", tick, 0);

    // R6 / R7 free running
    on_at = 4'd3; off_at = 4'd6;
    ready = 1'b1;
    wait_for("time zero", tz);
    chk("R6 tick at time zero", tick, 0);
    repeat (220) @(negedge clk);
    chk("R7 saturated tick", tick, TMAX);

    // R3 low half length
    prev = pull;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pull && !prev) break;
      prev = pull;
    end
    lowlen = 0;
    while (pull) begin lowlen++; @(negedge clk); end
    chk("R3 low half cycles", lowlen, HD);

    // R4 / R11 / R5 stretch by another device
    other = 1'b1;
    repeat (60) @(negedge clk);
    chk("R4 released while stretched", pull, 0);
    chk("R11 stall raised", stall, 1);
    other = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 no effect after two edges", stall, 1);
    @(negedge clk);
    chk("R5 rise seen on third edge", stall, 0);

    // R10 early low from another device during our high half
    prev = line;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (line && !prev) break;
      prev = line;
    end
    repeat (3) @(negedge clk);
    other = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 low half begins early", pull, 1);
    other = 1'b0;

    // R8 then R12
    ready = 1'b0;
    repeat (3) @(negedge clk);
    on_at = 4'd2; off_at = 4'd9;
    ready = 1'b1;
    wait_for("on event", on_evt);
    chk("R8 tick at on event", tick, 2);
    chk("R8 rail on", rail, 1);
    ready = 1'b0;
    @(negedge clk);
    chk("R12 pull after drop", pull, 1);
    chk("R12 tick cleared", tick, 0);
    chk("R12 rail cleared", rail, 0);

    // R9 after enable
    on_at = 4'd2; off_at = 4'd5;
    repeat (2) @(negedge clk);
    ready = 1'b1;
    wait_for("off event", off_evt);
    chk("R9 tick at off event", tick, 5);
    chk("R9 rail off", rail, 0);

    // R9 equal values: disable wins
    ready = 1'b0;
    on_at = 4'd3; off_at = 4'd3;
    repeat (2) @(negedge clk);
    ready = 1'b1;
    saw_rail = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (rail) saw_rail = 1'b1;
      if (off_evt) break;
    end
    chk("R9 equal off event tick", tick, 3);
    chk("R9 equal rail never on", saw_rail, 0);

    // R2 fault holds the line
    fault = 1'b1;
    @(negedge clk);
    chk("R2 fault pull", pull, 1);
    chk("R2 fault tick", tick, 0);
    repeat (5) @(negedge clk);
    fault = 1'b0;
    repeat (40) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule